// File: doc/BRIEF.md
# Bitstream Header Clock-to-Data Ratio Selector

This block watches the opening words of a 32-bit configuration bitstream as they pass on a valid/data word interface. It does not store, decrypt or decompress the stream. It reads an encryption field from one fixed header word and a compression bit from a later fixed header word. From those two facts and the bus width chosen for configuration (16 or 32 bits), it works out the clock-to-data ratio code that the configuration controller must be programmed with.

A controller pulses `start_i` with the intended width on `width32_i` and then streams the image. When word 229 has been accepted, `done_o` rises and `ratio_o` carries the code. If the stream ends before that word, `len_err_o` rises and no ratio is given. Both results hold until the next start pulse.

Control is a four-state machine:
- `ST_IDLE` is entered on reset.
- `ST_SCAN` is entered on a start pulse from any state.
- `ST_DONE` is entered from `ST_SCAN` when word 229 is accepted.
- `ST_FAULT` is entered from `ST_SCAN` when `stream_end_i` arrives first.
- `ST_DONE` and `ST_FAULT` leave only on a start pulse.

Top module: `hdr_ratio_sel`

## Requirements
- R1: A synchronous active-high reset clears the word count, the captured flags and all outputs (`ratio_o`=0, `width32_o`=0, `done_o`=0, `len_err_o`=0).
- R2: A `start_i` pulse clears the count, the flags, `done_o`, `len_err_o` and `ratio_o`, and latches `width32_i` onto `width32_o` (1 = 32-bit bus, 0 = 16-bit bus).
- R3: The word index (counting from 0) advances only on cycles with `beat_valid_i` high while scanning. Beats seen outside a scan are ignored.
- R4: The stream counts as encrypted when bits [3:2] of word 69 are nonzero. The same bits in other words have no effect.
- R5: The stream counts as compressed when bit 1 of word 229 is 0. The same bit in other words has no effect.
- R6: `done_o` is low until word 229 is accepted. It is high from the cycle after that beat, and it and `ratio_o` hold until the next start.
- R7: If `stream_end_i` arrives while scanning before word 229 is accepted, `len_err_o` rises in the next cycle with `done_o`=0 and `ratio_o`=0, and holds until the next start.
- R8: With neither encryption nor compression, the ratio code is 0 (x1) at both widths.
- R9: At 16-bit width, encryption alone gives code 1 (x2), and compression with or without encryption gives code 2 (x4).
- R10: At 32-bit width, encryption alone gives code 2 (x4), and compression with or without encryption gives code 3 (x8). This is the 16-bit code plus one, except for x1.
- R11: `ratio_o` is a 2-bit log2 code: 0=x1, 1=x2, 2=x4, 3=x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that starts a new header scan |
| width32_i | input | 1 | Bus width for the scan: 1 = 32-bit, 0 = 16-bit |
| beat_valid_i | input | 1 | Word on `beat_data_i` is valid this cycle |
| beat_data_i | input | 32 | Bitstream word |
| stream_end_i | input | 1 | The stream has ended |
| ratio_o | output | 2 | Clock-to-data ratio code (log2) |
| width32_o | output | 1 | Latched bus width selection |
| done_o | output | 1 | Ratio result is valid |
| len_err_o | output | 1 | Stream ended before word 229 |

## Verification
The assertions check the following on every cycle:
- `done_o` and `len_err_o` are never high together.
- A start clears both results.
- An error carries no ratio.
- A finished result holds steady.
- A 16-bit result never reaches x8, and a 32-bit non-unit result is at least x4.
- The word index stays bounded and moves only on valid beats.

Only the bench scenarios can show the following:
- That the right words and bits are decoded, including the inverted compression sense.
- That `done_o` rises exactly one cycle after word 229 and not after word 228.
- That a stream ending one word short is flagged.
- That beats outside a scan, or before a restart, do not shift the index.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } scan_state_e;

    localparam logic [1:0] RATIO_X1 = 2'd0;
    localparam logic [1:0] RATIO_X2 = 2'd1;
    localparam logic [1:0] RATIO_X4 = 2'd2;
    localparam logic [1:0] RATIO_X8 = 2'd3;

endpackage

// File: rtl/hdr_word_tracker.sv
module hdr_word_tracker #(
    parameter int DATA_W   = 32,
    parameter int ENC_WORD = 69,
    parameter int ENC_LSB  = 2,
    parameter int ENC_BITS = 2,
    parameter int CMP_WORD = 229,
    parameter int CMP_BIT  = 1,
    localparam int CNT_W   = $clog2(CMP_WORD + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              scan_en,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    output logic              last_beat,
    output logic              enc_flag,
    output logic              cmp_flag
);

    logic [CNT_W-1:0] idx_q;
    logic             enc_q;
    logic             take;

    assign take      = scan_en && beat_valid;
    assign last_beat = take && (idx_q == CNT_W'(CMP_WORD));
    assign enc_flag  = enc_q;
    // compression sense is inverted: bit clear means compressed
    assign cmp_flag  = ~beat_data[CMP_BIT];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
            enc_q <= 1'b0;
        end else if (take) begin
            if (idx_q != CNT_W'(CMP_WORD))
                idx_q <= idx_q + 1'b1;
            if (idx_q == CNT_W'(ENC_WORD))
                enc_q <= |beat_data[ENC_LSB +: ENC_BITS];
        end
    end

    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (rst)
        idx_q <= CNT_W'(CMP_WORD));

    assert_idx_still_R3: assert property (@(posedge clk) disable iff (rst)
        (!beat_valid && !clear) |=> $stable(idx_q));

endmodule

// File: rtl/hdr_ratio_decode.sv
module hdr_ratio_decode
    import hdr_ratio_pkg::*;
(
    input  logic       enc,
    input  logic       cmp,
    input  logic       wide,
    output logic [1:0] code
);

    logic [1:0] narrow_code;

    always_comb begin
        if (cmp)
            narrow_code = RATIO_X4;
        else if (enc)
            narrow_code = RATIO_X2;
        else
            narrow_code = RATIO_X1;

        if (wide && (narrow_code != RATIO_X1))
            code = narrow_code + 2'd1;
        else
            code = narrow_code;
    end

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
    import hdr_ratio_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ENC_WORD = 69,
    parameter int CMP_WORD = 229
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              width32_i,
    input  logic              beat_valid_i,
    input  logic [DATA_W-1:0] beat_data_i,
    input  logic              stream_end_i,
    output logic [1:0]        ratio_o,
    output logic              width32_o,
    output logic              done_o,
    output logic              len_err_o
);

    scan_state_e state_q, state_d;
    logic        last_beat, enc_flag, cmp_flag;
    logic [1:0]  code;
    logic [1:0]  ratio_q;
    logic        wide_q, done_q, err_q;
    logic        scanning;

    assign scanning = (state_q == ST_SCAN) && !start_i;

    hdr_word_tracker #(
        .DATA_W   (DATA_W),
        .ENC_WORD (ENC_WORD),
        .ENC_LSB  (2),
        .ENC_BITS (2),
        .CMP_WORD (CMP_WORD),
        .CMP_BIT  (1)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_i),
        .scan_en    (scanning),
        .beat_valid (beat_valid_i),
        .beat_data  (beat_data_i),
        .last_beat  (last_beat),
        .enc_flag   (enc_flag),
        .cmp_flag   (cmp_flag)
    );

    hdr_ratio_decode u_dec (
        .enc  (enc_flag),
        .cmp  (cmp_flag),
        .wide (wide_q),
        .code (code)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SCAN;
            ST_SCAN: begin
                if (start_i)           state_d = ST_SCAN;
                else if (last_beat)    state_d = ST_DONE;
                else if (stream_end_i) state_d = ST_FAULT;
            end
            ST_DONE:  if (start_i) state_d = ST_SCAN;
            ST_FAULT: if (start_i) state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= RATIO_X1;
            wide_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (start_i) begin
            ratio_q <= RATIO_X1;
            wide_q  <= width32_i;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (scanning && last_beat) begin
            ratio_q <= code;
            done_q  <= 1'b1;
        end else if (scanning && stream_end_i) begin
            err_q   <= 1'b1;
        end
    end

    assign ratio_o   = ratio_q;
    assign width32_o = wide_q;
    assign done_o    = done_q;
    assign len_err_o = err_q;

    assert_excl_result_R7: assert property (@(posedge clk) disable iff (rst)
        !(done_o && len_err_o));

    assert_err_no_ratio_R7: assert property (@(posedge clk) disable iff (rst)
        len_err_o |-> (ratio_o == RATIO_X1));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && !len_err_o && ratio_o == RATIO_X1));

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(ratio_o)));

    assert_narrow_cap_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !width32_o) |-> (ratio_o != RATIO_X8));

    assert_wide_step_R10: assert property (@(posedge clk) disable iff (rst)
        (done_o && width32_o && ratio_o != RATIO_X1) |-> (ratio_o >= RATIO_X4));

endmodule

// File: tb/tb_hdr_ratio_sel.sv
module tb_hdr_ratio_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, width32_i, beat_valid_i, stream_end_i;
    logic [31:0] beat_data_i;
    logic [1:0]  ratio_o;
    logic        width32_o, done_o, len_err_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hdr_ratio_sel dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .width32_i    (width32_i),
        .beat_valid_i (beat_valid_i),
        .beat_data_i  (beat_data_i),
        .stream_end_i (stream_end_i),
        .ratio_o      (ratio_o),
        .width32_o    (width32_o),
        .done_o       (done_o),
        .len_err_o    (len_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bits[3:2]=11 and bit1=0 in ordinary words, so a wrong-word decode shows up
    function automatic logic [31:0] fill(input int i);
        return 32'h5A00_000D ^ (32'(i) << 8);
    endfunction

    function automatic logic [31:0] word_at(input int i, input logic [1:0] encf, input logic cmpb);
        logic [31:0] w = fill(i);
        if (i == 69)  w[3:2] = encf;
        if (i == 229) w[1] = cmpb;
        return w;
    endfunction

    function automatic logic [1:0] exp_code(input logic w, input logic [1:0] encf, input logic cmpb);
        logic e = (encf != 2'b00);
        logic c = (cmpb == 1'b0);
        if (!e && !c) return 2'd0;
        if (!w) return c ? 2'd2 : 2'd1;
        return c ? 2'd3 : 2'd2;
    endfunction

    task automatic begin_scan(input logic w);
        @(negedge clk);
        start_i = 1'b1; width32_i = w; beat_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; width32_i = ~w;
        chk("R2 width latch", 32'(width32_o), 32'(w));
        chk("R2 done cleared", 32'(done_o), 0);
    endtask

    task automatic feed(input int n, input logic [1:0] encf, input logic cmpb);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            beat_valid_i = 1'b1; beat_data_i = word_at(i, encf, cmpb);
        end
        @(negedge clk);
        beat_valid_i = 1'b0; beat_data_i = 32'hFFFF_FFF0;
    endtask

    task automatic run_full(input string req, input logic w, input logic [1:0] encf,
                            input logic cmpb, input bit gaps);
        logic [1:0] e = exp_code(w, encf, cmpb);
        begin_scan(w);
        for (int i = 0; i < 230; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                beat_valid_i = 1'b0; beat_data_i = 32'h0000_0000;
            end
            @(negedge clk);
            if (i == 229) chk("R6 no early done", 32'(done_o), 0);
            beat_valid_i = 1'b1; beat_data_i = word_at(i, encf, cmpb);
        end
        @(negedge clk);
        beat_valid_i = 1'b0;
        chk("R6 done after word 229", 32'(done_o), 1);
        chk({req, " ratio"}, 32'(ratio_o), 32'(e));
        chk("R7 no error on full", 32'(len_err_o), 0);
        beat_valid_i = 1'b1; beat_data_i = 32'h0;
        repeat (3) @(negedge clk);
        beat_valid_i = 1'b0;
        chk("R6 done holds", 32'(done_o), 1);
        chk("R6 ratio holds", 32'(ratio_o), 32'(e));
    endtask

    task automatic run_short(input string req, input int n);
        begin_scan(1'b1);
        feed(n, 2'b11, 1'b0);
        stream_end_i = 1'b1;
        @(negedge clk);
        stream_end_i = 1'b0;
        chk({req, " error"}, 32'(len_err_o), 1);
        chk("R7 no done", 32'(done_o), 0);
        chk("R7 no ratio", 32'(ratio_o), 0);
        feed(240, 2'b11, 1'b0);
        chk("R7 error holds", 32'(len_err_o), 1);
        chk("R3 beats ignored in fault", 32'(done_o), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; width32_i = 1'b0; beat_valid_i = 1'b0;
        beat_data_i = '0; stream_end_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ratio", 32'(ratio_o), 0);
        chk("R1 width", 32'(width32_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 error", 32'(len_err_o), 0);
        // R3 beats before any start are ignored
        feed(60, 2'b00, 1'b1);
        chk("R3 idle beats ignored", 32'(done_o), 0);
        run_full("R8 x1 narrow", 1'b0, 2'b00, 1'b1, 1'b0);
        run_full("R8 x1 wide",   1'b1, 2'b00, 1'b1, 1'b0);
        run_full("R4 R9 enc narrow", 1'b0, 2'b01, 1'b1, 1'b0);
        run_full("R4 R10 enc wide",  1'b1, 2'b10, 1'b1, 1'b0);
        run_full("R5 R9 cmp narrow", 1'b0, 2'b00, 1'b0, 1'b0);
        run_full("R9 cmp+enc narrow", 1'b0, 2'b11, 1'b0, 1'b1);
        run_full("R5 R10 cmp wide",  1'b1, 2'b00, 1'b0, 1'b1);
        run_full("R10 R11 cmp+enc wide", 1'b1, 2'b11, 1'b0, 1'b0);
        // R2 restart mid-stream resets the index
        begin_scan(1'b0);
        feed(100, 2'b00, 1'b1);
        run_full("R2 restart", 1'b1, 2'b01, 1'b1, 1'b0);
        run_short("R7 early end", 40);
        run_short("R7 one short", 229);
        // R1 reset after a result clears it
        run_full("R11 x8", 1'b1, 2'b00, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears done", 32'(done_o), 0);
        chk("R1 reset clears ratio", 32'(ratio_o), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule